// File: doc/BRIEF.md
# Wildcard Time-of-Day Alarm Matcher

This block holds three alarm bytes (hour, minute, second) and compares them against the current time bytes once per one-second update. A match is reported as a single-cycle pulse, `match_o`, in the same cycle as the update-done strobe. The current time bytes must already hold the incremented values during that strobe. The pulse feeds the downstream alarm flag. Interrupt enables and date comparison are handled elsewhere.

Each alarm byte acts as a don't-care for its field when it holds FFH. This gives hourly, per-minute and per-second alarms, as well as irregular patterns such as every second of minute zero. Any other byte value matches only when it is bit-for-bit equal to the current field. The alarm bytes are written through a simple select and data strobe. A write that arrives while the time-keeping logic reports an update in progress is rejected, and the stored bytes keep their old values.

Top module: `alm_match_top`

## Requirements
- R1: During and after reset, all three alarm bytes read 00H, and `match_o` is low while no update-done strobe is present.
- R2: When `upd_done_i` is high and each current field equals its alarm byte, `match_o` is high in that same cycle.
- R3: `match_o` is never high in a cycle where `upd_done_i` is low.
- R4: An alarm byte of FFH matches every value of its field, so an all-FFH alarm matches on every update-done strobe.
- R5: Any alarm byte other than FFH matches only an identical 8-bit current value. There is no masking: FEH does not match FFH, and 80H does not match 00H.
- R6: A write with `alm_wr_i` high while `upd_busy_i` is high changes no alarm byte.
- R7: A write with `upd_busy_i` low stores `alm_wdata_i` into the byte chosen by `alm_sel_i`, visible on the next clock edge. The select codes are 0 for second, 1 for minute and 2 for hour.
- R8: A write with select code 3 changes no alarm byte.
- R9: Over consecutive per-second updates, the patterns behave as follows. FF:00:00 fires once per hour. FF:FF:00 fires once per minute. FF:00:FF fires on every second of minute zero of each hour. 00:FF:00 fires once per minute during hour zero only. 00:00:00 fires once per day.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_busy_i | input | 1 | Update in progress; alarm writes are rejected while high |
| upd_done_i | input | 1 | Update-done strobe; current time bytes are post-increment |
| cur_sec_i | input | 8 | Current second byte |
| cur_min_i | input | 8 | Current minute byte |
| cur_hour_i | input | 8 | Current hour byte |
| alm_wr_i | input | 1 | Alarm byte write strobe |
| alm_sel_i | input | 2 | Alarm byte select: 0 second, 1 minute, 2 hour, 3 none |
| alm_wdata_i | input | 8 | Alarm write data |
| alm_sec_o | output | 8 | Stored alarm second byte |
| alm_min_o | output | 8 | Stored alarm minute byte |
| alm_hour_o | output | 8 | Stored alarm hour byte |
| match_o | output | 1 | Single-cycle alarm match pulse |

## Verification
A corrupted alarm byte is visible on its readback port one cycle after the faulty write. At the next update-done strobe it also shows as a missed or spurious pulse. A fault in one field comparator, or in the wildcard detection, changes the pulse count over a long sweep of consecutive seconds. The bench therefore counts pulses for each pattern across three simulated hours and compares the totals with values derived from the calendar. Rejected writes and select code 3 are checked by reading back all three bytes right after the attempted write.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int unsigned NUM_FIELDS = 3;
  localparam int unsigned SEL_W      = $clog2(NUM_FIELDS + 1);

  typedef enum logic [SEL_W-1:0] {
    SEL_SEC  = 2'd0,
    SEL_MIN  = 2'd1,
    SEL_HOUR = 2'd2,
    SEL_NONE = 2'd3
  } alm_sel_e;
endpackage

// File: rtl/alm_reg_bank.sv
module alm_reg_bank
  import alm_pkg::*;
#(
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned NF      = NUM_FIELDS,
  parameter logic [FIELD_W-1:0] RST_VAL = '0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic                       busy_i,
  input  logic [SEL_W-1:0]           sel_i,
  input  logic [FIELD_W-1:0]         wdata_i,
  output logic [NF-1:0][FIELD_W-1:0] regs_o
);
  logic wr_ok;
  assign wr_ok = wr_i && !busy_i;

  for (genvar g = 0; g < NF; g++) begin : g_fld
    logic [FIELD_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q <= RST_VAL;
      else if (wr_ok && sel_i == SEL_W'(g))       q <= wdata_i;
    end
    assign regs_o[g] = q;
  end
endmodule

// File: rtl/alm_field_cmp.sv
module alm_field_cmp #(
  parameter int unsigned FIELD_W = 8,
  parameter logic [FIELD_W-1:0] WILD = '1
) (
  input  logic [FIELD_W-1:0] alarm_i,
  input  logic [FIELD_W-1:0] cur_i,
  output logic               hit_o
);
  logic is_wild;
  logic is_eq;
  assign is_wild = (alarm_i == WILD);
  assign is_eq   = (alarm_i == cur_i);  // exact, no BCD/range awareness
  assign hit_o   = is_wild || is_eq;
endmodule

// File: rtl/alm_match_top.sv
module alm_match_top
  import alm_pkg::*;
#(
  parameter int unsigned FIELD_W = 8,
  parameter logic [FIELD_W-1:0] WILD    = '1,
  parameter logic [FIELD_W-1:0] RST_VAL = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_busy_i,
  input  logic               upd_done_i,
  input  logic [FIELD_W-1:0] cur_sec_i,
  input  logic [FIELD_W-1:0] cur_min_i,
  input  logic [FIELD_W-1:0] cur_hour_i,
  input  logic               alm_wr_i,
  input  logic [1:0]         alm_sel_i,
  input  logic [FIELD_W-1:0] alm_wdata_i,
  output logic [FIELD_W-1:0] alm_sec_o,
  output logic [FIELD_W-1:0] alm_min_o,
  output logic [FIELD_W-1:0] alm_hour_o,
  output logic               match_o
);
  localparam int unsigned NF = NUM_FIELDS;

  logic [NF-1:0][FIELD_W-1:0] alm_q;
  logic [NF-1:0][FIELD_W-1:0] cur;
  logic [NF-1:0]              hit;

  assign cur[SEL_SEC]  = cur_sec_i;
  assign cur[SEL_MIN]  = cur_min_i;
  assign cur[SEL_HOUR] = cur_hour_i;

  alm_reg_bank #(
    .FIELD_W(FIELD_W),
    .NF     (NF),
    .RST_VAL(RST_VAL)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (alm_wr_i),
    .busy_i (upd_busy_i),
    .sel_i  (SEL_W'(alm_sel_i)),
    .wdata_i(alm_wdata_i),
    .regs_o (alm_q)
  );

  for (genvar g = 0; g < NF; g++) begin : g_cmp
    alm_field_cmp #(
      .FIELD_W(FIELD_W),
      .WILD   (WILD)
    ) u_cmp (
      .alarm_i(alm_q[g]),
      .cur_i  (cur[g]),
      .hit_o  (hit[g])
    );
  end

  // pulse aligned with the strobe; time inputs are already post-increment
  assign match_o    = upd_done_i && (&hit);
  assign alm_sec_o  = alm_q[SEL_SEC];
  assign alm_min_o  = alm_q[SEL_MIN];
  assign alm_hour_o = alm_q[SEL_HOUR];
endmodule

// File: rtl/alm_match_chk.sv
module alm_match_chk #(
  parameter int unsigned FIELD_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               upd_busy_i,
  input logic               upd_done_i,
  input logic [FIELD_W-1:0] cur_sec_i,
  input logic [FIELD_W-1:0] cur_min_i,
  input logic [FIELD_W-1:0] cur_hour_i,
  input logic               alm_wr_i,
  input logic [1:0]         alm_sel_i,
  input logic [FIELD_W-1:0] alm_wdata_i,
  input logic [FIELD_W-1:0] alm_sec_o,
  input logic [FIELD_W-1:0] alm_min_o,
  input logic [FIELD_W-1:0] alm_hour_o,
  input logic               match_o
);
  a_r3_match_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> upd_done_i);

  a_r2_exact_fires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_done_i && cur_sec_i == alm_sec_o && cur_min_i == alm_min_o
     && cur_hour_i == alm_hour_o) |-> match_o);

  a_r4_all_wild_fires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_done_i && &alm_sec_o && &alm_min_o && &alm_hour_o) |-> match_o);

  a_r6_busy_write_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alm_wr_i && upd_busy_i) |=>
      ($stable(alm_sec_o) && $stable(alm_min_o) && $stable(alm_hour_o)));

  a_r7_sec_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alm_wr_i && !upd_busy_i && alm_sel_i == 2'd0) |=>
      (alm_sec_o == $past(alm_wdata_i)));

  a_r8_sel3_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alm_wr_i && alm_sel_i == 2'd3) |=>
      ($stable(alm_sec_o) && $stable(alm_min_o) && $stable(alm_hour_o)));
endmodule

bind alm_match_top alm_match_chk #(.FIELD_W(FIELD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .upd_busy_i (upd_busy_i),
  .upd_done_i (upd_done_i),
  .cur_sec_i  (cur_sec_i),
  .cur_min_i  (cur_min_i),
  .cur_hour_i (cur_hour_i),
  .alm_wr_i   (alm_wr_i),
  .alm_sel_i  (alm_sel_i),
  .alm_wdata_i(alm_wdata_i),
  .alm_sec_o  (alm_sec_o),
  .alm_min_o  (alm_min_o),
  .alm_hour_o (alm_hour_o),
  .match_o    (match_o)
);

// File: tb/alm_match_top_test.sv
module alm_match_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       busy = 1'b0, done = 1'b0, wr = 1'b0;
  logic [7:0] cs = '0, cm = '0, ch = '0, wd = '0;
  logic [1:0] sel = '0;
  logic [7:0] a_s, a_m, a_h;
  logic       match;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  alm_match_top uut (
    .clk_i(clk), .rst_ni(rst_n), .upd_busy_i(busy), .upd_done_i(done),
    .cur_sec_i(cs), .cur_min_i(cm), .cur_hour_i(ch),
    .alm_wr_i(wr), .alm_sel_i(sel), .alm_wdata_i(wd),
    .alm_sec_o(a_s), .alm_min_o(a_m), .alm_hour_o(a_h), .match_o(match)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_alm(logic [1:0] s, logic [7:0] d, logic b);
    @(negedge clk); wr = 1'b1; sel = s; wd = d; busy = b;
    @(negedge clk); wr = 1'b0; busy = 1'b0;
  endtask

  task automatic set_alarm(logic [7:0] h, logic [7:0] m, logic [7:0] s);
    wr_alm(2'd2, h, 1'b0); wr_alm(2'd1, m, 1'b0); wr_alm(2'd0, s, 1'b0);
  endtask

  task automatic probe(logic [7:0] h, logic [7:0] m, logic [7:0] s, logic d, output logic r);
    @(negedge clk); ch = h; cm = m; cs = s; done = d;
    #1 r = match;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 sec", a_s, 8'h00); check("R1 min", a_m, 8'h00);
    check("R1 hour", a_h, 8'h00); check("R1 match", match, 0);
  endtask

  task automatic t_write();
    set_alarm(8'h12, 8'h34, 8'h56);
    check("R7 hour", a_h, 8'h12); check("R7 min", a_m, 8'h34); check("R7 sec", a_s, 8'h56);
  endtask

  task automatic t_busy();
    wr_alm(2'd0, 8'h01, 1'b1); wr_alm(2'd2, 8'h02, 1'b1);
    check("R6 sec kept", a_s, 8'h56); check("R6 hour kept", a_h, 8'h12);
    check("R6 min kept", a_m, 8'h34);
  endtask

  task automatic t_sel3();
    wr_alm(2'd3, 8'h77, 1'b0);
    check("R8 sec", a_s, 8'h56); check("R8 min", a_m, 8'h34); check("R8 hour", a_h, 8'h12);
  endtask

  task automatic t_exact();
    logic r;
    probe(8'h12, 8'h34, 8'h56, 1'b1, r); check("R2 exact hit", r, 1);
    probe(8'h12, 8'h34, 8'h57, 1'b1, r); check("R2 sec off", r, 0);
    probe(8'h12, 8'h34, 8'h56, 1'b0, r); check("R3 no strobe", r, 0);
  endtask

  task automatic t_strict();
    logic r;
    set_alarm(8'h80, 8'h00, 8'hFE);
    probe(8'h00, 8'h00, 8'hFE, 1'b1, r); check("R5 80 vs 00", r, 0);
    probe(8'h80, 8'h00, 8'hFF, 1'b1, r); check("R5 FE vs FF", r, 0);
    probe(8'h80, 8'h00, 8'hFE, 1'b1, r); check("R5 identical", r, 1);
    set_alarm(8'hFF, 8'hFF, 8'hFF);
    probe(8'hA5, 8'h3B, 8'h7E, 1'b1, r); check("R4 all wild", r, 1);
    probe(8'hA5, 8'h3B, 8'h7E, 1'b0, r); check("R3 wild no strobe", r, 0);
  endtask

  // three hours of consecutive post-increment updates, one per cycle
  task automatic sweep(string tag, logic [7:0] h, logic [7:0] m, logic [7:0] s, int exp);
    int cnt = 0;
    set_alarm(h, m, s);
    for (int hh = 0; hh < 3; hh++)
      for (int mm = 0; mm < 60; mm++)
        for (int ss = 0; ss < 60; ss++) begin
          @(negedge clk); ch = 8'(hh); cm = 8'(mm); cs = 8'(ss); done = 1'b1;
          #1 if (match) cnt++;
        end
    @(negedge clk); done = 1'b0;
    check(tag, cnt, exp);
  endtask

  initial begin
    #(150000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #35; t_reset();
    rst_n = 1'b1;
    @(negedge clk); t_reset();
    t_write(); t_busy(); t_sel3(); t_exact(); t_strict();
    sweep("R9 daily 00:00:00", 8'h00, 8'h00, 8'h00, 1);
    sweep("R9 hourly FF:00:00", 8'hFF, 8'h00, 8'h00, 3);
    sweep("R9 minutely FF:FF:00", 8'hFF, 8'hFF, 8'h00, 180);
    sweep("R9 FF:00:FF", 8'hFF, 8'h00, 8'hFF, 180);
    sweep("R9 00:FF:00", 8'h00, 8'hFF, 8'h00, 60);
    sweep("R4 FF:FF:FF", 8'hFF, 8'hFF, 8'hFF, 10800);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule